// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Replay

This block is an on-chip scratchpad that sixteen parallel lanes share, one request at a time. Each lane brings its own enable, word address, write flag and 32-bit write data. The words are interleaved over sixteen banks, so the low four bits of a word address choose the bank. A two-dimensional array stored in rows of sixteen words therefore puts one whole row across all banks, and all of one column into a single bank.

A request is accepted through a valid/ready handshake. In every following cycle each bank serves one address: the address of its lowest-numbered pending lane, together with every other pending lane that uses that same address. Lanes that hit one bank at different addresses are replayed in later cycles. Lanes that share a word are served in one go as a broadcast. Once every lane has been served, a one-cycle done pulse presents the read data for all lanes. A saturating counter adds up the extra cycles spent on conflicts.

Top module: `banked_scratch`

## Requirements
- R1: After reset, req_ready is 1, rsp_done is 0, conflict_count is 0, rsp_rdata is 0 and every storage word reads as 0.
- R2: The bank of a word is address bits [3:0]. Lane l uses lane_addr[l*8 +: 8], lane_wdata[l*32 +: 32] and rsp_rdata[l*32 +: 32]. A request whose enabled lanes all use different banks takes one serving cycle. rsp_done is high for exactly one cycle, sampled after the N-th clock edge that follows the accepting edge, where N is the number of serving cycles.
- R3: N equals the largest number of distinct addresses that the enabled lanes place in any one bank.
- R4: Enabled lanes that use the identical address are served in the same cycle and add no serving cycle.
- R5: For each enabled lane with lane_we=0, the read data is the word's contents before the request, even when another lane of the same request writes that word. Write lanes and disabled lanes return 0. The data holds from the done cycle until the next request is accepted.
- R6: When several enabled lanes of one request write the same word, the word takes the data of the highest-numbered such lane.
- R7: conflict_count adds N-1 on completion of each request. The new value is visible together with rsp_done. It saturates at all ones and changes at no other time.
- R8: req_ready is low from the accepting edge until the done cycle. Input values presented during that time do not affect the request in flight.
- R9: A request with no enabled lanes takes one serving cycle and adds 0 to conflict_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on this edge if valid |
| lane_en | input | 16 | Per-lane enable |
| lane_we | input | 16 | Per-lane write flag (1 = write) |
| lane_addr | input | 128 | Per-lane word address, 8 bits per lane |
| lane_wdata | input | 512 | Per-lane write data, 32 bits per lane |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 512 | Per-lane read data, 32 bits per lane |
| conflict_count | output | 32 | Saturating total of extra conflict cycles |

## Verification
Within a single serving cycle, a broadcast and a conflict replay can both act on the same bank. They overlap when some lanes share one address while other lanes hit that bank at a different address. Requests made of two broadcast groups that land in one bank, and lanes that read and write one word in the same request, bring these cases together. The bench judges them against a behavioural model that computes, at acceptance, the cycle count and every lane's read data, and it compares ready, done, counter and data with the design on every clock.

// File: rtl/banked_scratch.sv
module banked_scratch #(
  parameter int LANES = 16,
  parameter int BANKS = 16,
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int CW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [LANES-1:0]          lane_en,
  input  logic [LANES-1:0]          lane_we,
  input  logic [LANES*$clog2(BANKS*DEPTH)-1:0] lane_addr,
  input  logic [LANES*DW-1:0]       lane_wdata,
  output logic                      rsp_done,
  output logic [LANES*DW-1:0]       rsp_rdata,
  output logic [CW-1:0]             conflict_count
);
  localparam int BB = $clog2(BANKS);
  localparam int NW = BANKS * DEPTH;
  localparam int AW = $clog2(NW);
  localparam int KW = $clog2(LANES + 1);

  logic              busy;
  logic [LANES-1:0]  pend, we_q, serve;
  logic [AW-1:0]     addr_q [LANES];
  logic [DW-1:0]     wd_q   [LANES];
  logic [DW-1:0]     rd_q   [LANES];
  logic [AW-1:0]     lead   [BANKS];
  logic [DW-1:0]     mem    [NW];
  logic [KW-1:0]     cyc;
  logic [CW:0]       sum;
  logic              last;

  assign req_ready = !busy;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rsp_rdata[g*DW +: DW] = rd_q[g];
  end

  always_comb begin
    for (int b = 0; b < BANKS; b++) lead[b] = '0;
    for (int l = LANES - 1; l >= 0; l--)
      if (pend[l]) lead[addr_q[l][BB-1:0]] = addr_q[l];
    for (int l = 0; l < LANES; l++)
      serve[l] = pend[l] && (addr_q[l] == lead[addr_q[l][BB-1:0]]);
  end

  assign last = (pend & ~serve) == '0;
  assign sum  = {1'b0, conflict_count} + {{(CW + 1 - KW){1'b0}}, cyc - KW'(1)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rsp_done <= 1'b0;
      pend <= '0;
      we_q <= '0;
      cyc <= '0;
      conflict_count <= '0;
      for (int l = 0; l < LANES; l++) begin
        addr_q[l] <= '0;
        wd_q[l] <= '0;
        rd_q[l] <= '0;
      end
      for (int w = 0; w < NW; w++) mem[w] <= '0;
    end else begin
      rsp_done <= 1'b0;
      if (req_valid && !busy) begin
        busy <= 1'b1;
        pend <= lane_en;
        we_q <= lane_we;
        cyc  <= KW'(1);
        for (int l = 0; l < LANES; l++) begin
          addr_q[l] <= lane_addr[l*AW +: AW];
          wd_q[l]   <= lane_wdata[l*DW +: DW];
          rd_q[l]   <= '0;
        end
      end else if (busy) begin
        pend <= pend & ~serve;
        for (int l = 0; l < LANES; l++) begin
          if (serve[l] && we_q[l])  mem[addr_q[l]] <= wd_q[l];
          if (serve[l] && !we_q[l]) rd_q[l] <= mem[addr_q[l]];
        end
        if (last) begin
          busy <= 1'b0;
          rsp_done <= 1'b1;
          conflict_count <= sum[CW] ? '1 : sum[CW-1:0];
        end else begin
          cyc <= cyc + KW'(1);
        end
      end
    end
  end

  p_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pend != '0) |-> (serve != '0));

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_count_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(conflict_count));

  p_count_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (conflict_count >= $past(conflict_count)));

  p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lane_en == '0) |=> ##1 rsp_done);
endmodule

// File: tb/banked_scratch_test.sv
module banked_scratch_test;
  localparam int L = 16, DW = 32, AW = 8, CW = 8;
  localparam int MAXC = 255;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [L-1:0] en = '0, we = '0;
  logic [AW-1:0] ad [L];
  logic [DW-1:0] wd [L];
  logic [L*AW-1:0] ad_v;
  logic [L*DW-1:0] wd_v;
  wire  [L*DW-1:0] rd_v;
  wire  req_ready, rsp_done;
  wire  [CW-1:0] cc;

  always #2 clk = ~clk;

  always_comb
    for (int l = 0; l < L; l++) begin
      ad_v[l*AW +: AW] = ad[l];
      wd_v[l*DW +: DW] = wd[l];
    end

  banked_scratch #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .lane_en(en), .lane_we(we), .lane_addr(ad_v), .lane_wdata(wd_v),
    .rsp_done(rsp_done), .rsp_rdata(rd_v), .conflict_count(cc));

  int checks = 0, fails = 0;
  logic [DW-1:0] mmem [256];
  logic [DW-1:0] m_rd [L];
  logic [DW-1:0] m_pend [L];
  bit m_busy, m_done, live = 0, acc;
  int m_left, m_cyc, m_cnt;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] val(int a);
    return 32'hA000_0000 + a * 3;
  endfunction

  function automatic void model_accept();
    int bc [16];
    int mx;
    for (int b = 0; b < 16; b++) bc[b] = 0;
    for (int l = 0; l < L; l++)
      if (en[l]) begin
        bit dup = 0;
        for (int k = 0; k < l; k++) if (en[k] && ad[k] == ad[l]) dup = 1;
        if (!dup) bc[ad[l] % 16]++;
      end
    mx = 1;
    for (int b = 0; b < 16; b++) if (bc[b] > mx) mx = bc[b];
    for (int l = 0; l < L; l++) m_pend[l] = (en[l] && !we[l]) ? mmem[ad[l]] : '0;
    for (int l = 0; l < L; l++) if (en[l] && we[l]) mmem[ad[l]] = wd[l];
    m_cyc = mx; m_left = mx; m_busy = 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0;
      for (int w = 0; w < 256; w++) mmem[w] = '0;
      for (int l = 0; l < L; l++) m_rd[l] = '0;
    end else begin
      acc = req_valid && !m_busy;
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1;
          m_cnt = m_cnt + m_cyc - 1;
          if (m_cnt > MAXC) m_cnt = MAXC;
          for (int l = 0; l < L; l++) m_rd[l] = m_pend[l];
        end
      end
      if (acc) model_accept();
    end
  end

  always @(negedge clk)
    if (live) begin
      chk("R8 ready", req_ready, !m_busy);
      chk("R2 R3 done", rsp_done, m_done);
      chk("R7 count", cc, m_cnt);
      if (!m_busy)
        for (int l = 0; l < L; l++) chk("R5 rdata", rd_v[l*DW +: DW], m_rd[l]);
    end

  task automatic clear();
    en = '0; we = '0;
    for (int l = 0; l < L; l++) begin ad[l] = '0; wd[l] = '0; end
  endtask

  task automatic issue();
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run(string req, int n_exp, int d_exp);
    int c0, n;
    c0 = cc;
    issue();
    n = 0;
    while (!rsp_done) begin @(negedge clk); n++; end
    chk({req, " cycles"}, n, n_exp);
    if (d_exp >= 0) chk({req, " extra"}, cc - c0, d_exp);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1;
    chk("R1 ready", req_ready, 1);
    chk("R1 done", rsp_done, 0);
    chk("R1 count", cc, 0);

    clear(); en = '1;
    for (int l = 0; l < L; l++) ad[l] = AW'(48 + l);
    run("R1", 1, 0);
    chk("R1 zero word", rd_v[5*DW +: DW], 0);

    for (int r = 0; r < 16; r++) begin
      clear(); en = '1; we = '1;
      for (int l = 0; l < L; l++) begin ad[l] = AW'(r*16 + l); wd[l] = val(r*16 + l); end
      run("R2 row write", 1, 0);
    end

    clear(); en = '1;
    for (int l = 0; l < L; l++) ad[l] = AW'(l*16 + 5);
    run("R3 column", 16, 15);
    chk("R5 column data", rd_v[7*DW +: DW], val(7*16 + 5));

    clear(); en = '1;
    for (int l = 0; l < L; l++) ad[l] = AW'(9*16 + l);
    run("R2 row read", 1, 0);

    clear(); en = '1;
    for (int l = 0; l < L; l++) ad[l] = AW'(37);
    run("R4 broadcast", 1, 0);
    chk("R4 data", rd_v[15*DW +: DW], val(37));

    clear(); en = '1;
    for (int l = 0; l < L; l++) ad[l] = AW'((l % 8) + 16 * (l / 8));
    run("R3 two way", 2, 1);

    clear(); en = '1;
    for (int l = 0; l < L; l++) ad[l] = (l < 8) ? AW'(4) : AW'(20);
    run("R4 two groups", 2, 1);

    clear(); en = '1; we = '1;
    for (int l = 0; l < L; l++) begin ad[l] = AW'(50); wd[l] = 32'h5000 + l; end
    run("R6 write", 1, 0);
    clear(); en = 16'h0001; ad[0] = AW'(50);
    run("R6 read", 1, 0);
    chk("R6 winner", rd_v[0 +: DW], 32'h500F);

    clear(); en = 16'h0003; we = 16'h0002; ad[0] = AW'(60); ad[1] = AW'(60); wd[1] = 32'h6666;
    run("R5 rw", 1, 0);
    chk("R5 old data", rd_v[0 +: DW], val(60));
    chk("R5 write lane", rd_v[DW +: DW], 0);

    clear(); en = 16'h00F0;
    for (int l = 0; l < L; l++) ad[l] = AW'(2*16 + l);
    run("R5 partial", 1, 0);
    chk("R5 disabled", rd_v[0 +: DW], 0);
    chk("R5 enabled", rd_v[5*DW +: DW], val(37));

    clear();
    run("R9 empty", 1, 0);

    for (int i = 0; i < 300; i++) begin
      clear();
      en = L'($urandom);
      we = L'($urandom);
      for (int l = 0; l < L; l++) begin
        ad[l] = AW'($urandom_range(0, (i % 3 == 0) ? 31 : 255));
        wd[l] = $urandom;
      end
      issue();
      if (i % 4 == 0) while (!rsp_done) @(negedge clk);
    end
    while (!rsp_done) @(negedge clk);

    for (int i = 0; i < 20; i++) begin
      clear(); en = '1;
      for (int l = 0; l < L; l++) ad[l] = AW'(l*16 + 3);
      run("R7 saturate", 16, -1);
    end
    chk("R7 saturated", cc, MAXC);
    repeat (3) @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule